// File: doc/BRIEF.md
# Two-Wire Slave Access Tracker

This block watches the synchronized clock and data lines of a two-wire serial bus from the slave side. It finds bus conditions (START, repeated START, STOP), counts the bits of every nine-clock frame and collects the first byte after each START. That byte holds a 7-bit address and a direction bit, and the block compares it with a programmed slave address and with the general call address.

Using that decode, the block keeps track of the access. It reports whether the slave is currently addressed, which way the data moves, whether the access is a general call, a one-cycle end-of-access strobe and a slave-side completion flag. It also drives two bus requests. The first pulls data low in the acknowledge clock of every byte the slave must acknowledge. The second holds the clock low at a byte boundary when the byte buffers on the far side are not ready. Data shifting beyond the address, the pad drivers and any register access live outside this block.

Top module: `tws_slave_tracker`

## Requirements
- R1: After reset, `acc_o`, `rd_o`, `gcall_o`, `acc_end_o`, `hold_scl_o` and `ack_sda_o` are 0, and `done_o` is 1.
- R2: A START (data falling while clock is high) clears `done_o` one clock after the edge is seen on the inputs. A STOP (data rising while clock is high) sets `done_o`.
- R3: The first byte after any START is sampled most significant bit first on clock rising edges, and its eighth bit is the direction bit (1 = master reads). When bits 7..1 equal `own_addr_i`, `acc_o` is 1 after the eighth rising edge and `rd_o` equals the direction bit.
- R4: Once set, `acc_o` stays 1 across data bytes and across a repeated START that is followed by a matching address. A STOP clears it.
- R5: In a read access, the data value sampled at the ninth rising edge of a data byte is the master's acknowledge. A value of 1 (NACK) clears `acc_o`, and a value of 0 keeps it.
- R6: `acc_end_o` is high for exactly one clock, in the first cycle in which `acc_o` reads 0 after reading 1.
- R7: An address byte of 0x00 (address 0, direction 0) sets both `gcall_o` and `acc_o`. A byte of 0x01 sets neither unless it matches `own_addr_i`. `gcall_o` clears when the access ends.
- R8: A repeated START followed by an address that matches neither the slave address nor the general call sets `done_o` after the eighth rising edge and clears `acc_o`. After a START on an idle bus, a non-matching address leaves `done_o` at 0 until the next STOP.
- R9: `ack_sda_o` is 1 during the ninth clock of a matching address byte and of every data byte in a write access. It stays 0 in the ninth clock of a non-matching address and of read data bytes. It is asserted only after the clock has gone low.
- R10: After the ninth clock of a byte in an active access, while the clock is low, `hold_scl_o` equals `!tx_full_i` in a read access and `rx_full_i` in a write access. It drops when the clock rises, when the access ends, or when the buffer condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| own_addr_i | input | 7 | Programmed slave address |
| tx_full_i | input | 1 | Transmit buffer holds a byte for the next read byte |
| rx_full_i | input | 1 | Receive buffer still holds an unread byte |
| acc_o | output | 1 | Slave is addressed |
| rd_o | output | 1 | Direction of the access, 1 = master reads |
| gcall_o | output | 1 | Current access is a general call |
| acc_end_o | output | 1 | One-clock strobe when the access ends |
| done_o | output | 1 | Slave-side completion |
| hold_scl_o | output | 1 | Request to hold the bus clock low |
| ack_sda_o | output | 1 | Request to pull data low for an acknowledge |

## Verification
The bench goes after the cases that separate this tracker from a plain address decoder. A repeated START to another address has to raise completion, while the same mismatch on an idle bus must not; a design that treats every START alike would raise completion too early. The bench also checks that a master NACK ends only read accesses and only on data bytes. A design that looked at the address acknowledge, or at write bytes, would drop the access at once. The end-of-access strobe is counted against every modelled fall of the access flag, so a strobe that is missed, doubled or fires on a repeated START to the slave's own address shows up in the count. Clock holding is checked under random buffer states in both directions, which catches a swapped buffer polarity.

// File: rtl/tws_pkg.sv
// Shared types for the two-wire slave access tracker.
package tws_pkg;

    // Single-cycle bus events seen on the synchronized lines.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } tws_evt_t;

endpackage

// File: rtl/tws_line_events.sv
// Detects bus conditions and clock edges from synchronized lines.
// Assumes scl_i/sda_i are already synchronized to clk and that each
// line level lasts at least one clock. Events are combinational pulses.
module tws_line_events
    import tws_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output tws_evt_t evt_o
);

    logic scl_q;
    logic sda_q;

    // Keep the previous line levels; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode conditions: data edges while clock stays high.
    always_comb begin
        evt_o.start    = scl_q && scl_i && sda_q && !sda_i;
        evt_o.stop     = scl_q && scl_i && !sda_q && sda_i;
        evt_o.scl_rise = !scl_q && scl_i;
        evt_o.scl_fall = scl_q && !scl_i;
    end

endmodule

// File: rtl/tws_frame_counter.sv
// Counts clock pulses inside each nine-clock frame and collects the
// bits of the current byte, MSB first. Marks the acknowledge slot (from
// the falling edge after the eighth bit to the falling edge after the
// ninth) and whether the current frame is the first after a START.
module tws_frame_counter
    import tws_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tws_evt_t          evt_i,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_done_o,
    output logic              ack_rise_o,
    output logic              ack_end_o,
    output logic              ack_slot_o,
    output logic              first_o
);

    localparam int              CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] shreg;

    // The full byte is the earlier bits plus the bit on the line now.
    assign byte_o      = {shreg, sda_i};
    assign byte_done_o = evt_i.scl_rise && (cnt == LAST_BIT);
    assign ack_rise_o  = evt_i.scl_rise && (cnt == ACK_BIT);
    assign ack_end_o   = evt_i.scl_fall && ack_slot_o;

    // Bit counter, shift register and acknowledge-slot tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            shreg      <= '0;
            ack_slot_o <= 1'b0;
            first_o    <= 1'b1;
        end else if (evt_i.start || evt_i.stop) begin
            cnt        <= '0;
            ack_slot_o <= 1'b0;
            first_o    <= 1'b1;
        end else begin
            if (evt_i.scl_rise) begin
                if (cnt == ACK_BIT) begin
                    cnt <= '0;
                end else begin
                    cnt   <= cnt + 1'b1;
                    shreg <= {shreg[BYTE_W-3:0], sda_i};
                end
            end
            if (evt_i.scl_fall) begin
                if (ack_slot_o) begin
                    ack_slot_o <= 1'b0;
                    first_o    <= 1'b0;
                end else if (cnt == ACK_BIT) begin
                    ack_slot_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tws_access_ctrl.sv
// Tracks the slave access: address match, direction, general call,
// end-of-access strobe, completion flag and the byte-boundary flag
// used for clock holding. Assumes the frame counter marks the first
// frame after each START and pulses at the eighth and ninth rises.
module tws_access_ctrl
    import tws_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tws_evt_t          evt_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_done_i,
    input  logic              first_i,
    input  logic              ack_rise_i,
    input  logic              ack_end_i,
    output logic              acc_o,
    output logic              rd_o,
    output logic              gcall_o,
    output logic              acc_end_o,
    output logic              done_o,
    output logic              boundary_o
);

    logic busy_q, rep_q;
    logic acc_n, rd_n, gc_n, done_n, busy_n, rep_n, bnd_n;
    logic own_hit, gc_hit;

    // Address decode of the collected byte.
    assign own_hit = (byte_i[BYTE_W-1:1] == own_addr_i);
    assign gc_hit  = (byte_i == '0);

    // Next-state logic for all access flags.
    always_comb begin
        acc_n  = acc_o;
        rd_n   = rd_o;
        gc_n   = gcall_o;
        done_n = done_o;
        busy_n = busy_q;
        rep_n  = rep_q;
        bnd_n  = boundary_o;
        if (evt_i.start) begin
            done_n = 1'b0;
            rep_n  = busy_q;
            busy_n = 1'b1;
            bnd_n  = 1'b0;
        end else if (evt_i.stop) begin
            done_n = 1'b1;
            busy_n = 1'b0;
            rep_n  = 1'b0;
            acc_n  = 1'b0;
            gc_n   = 1'b0;
            bnd_n  = 1'b0;
        end else begin
            if (byte_done_i && first_i) begin
                acc_n = own_hit || gc_hit;
                gc_n  = gc_hit;
                rd_n  = byte_i[0];
                if (!(own_hit || gc_hit) && rep_q) begin
                    done_n = 1'b1;
                end
                rep_n = 1'b0;
            end
            if (ack_rise_i && !first_i && acc_o && rd_o && sda_i) begin
                acc_n = 1'b0;
                gc_n  = 1'b0;
            end
            if (ack_end_i && acc_n) begin
                bnd_n = 1'b1;
            end
            if (evt_i.scl_rise || !acc_n) begin
                bnd_n = 1'b0;
            end
        end
    end

    // State registers; the end strobe marks a falling access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o      <= 1'b0;
            rd_o       <= 1'b0;
            gcall_o    <= 1'b0;
            acc_end_o  <= 1'b0;
            done_o     <= 1'b1;
            busy_q     <= 1'b0;
            rep_q      <= 1'b0;
            boundary_o <= 1'b0;
        end else begin
            acc_o      <= acc_n;
            rd_o       <= rd_n;
            gcall_o    <= gc_n;
            acc_end_o  <= acc_o && !acc_n;
            done_o     <= done_n;
            busy_q     <= busy_n;
            rep_q      <= rep_n;
            boundary_o <= bnd_n;
        end
    end

endmodule

// File: rtl/tws_bus_requests.sv
// Forms the two bus requests: acknowledge pull-down on data and
// clock holding at byte boundaries. Purely combinational on the
// registered state of the counter and the access controller.
module tws_bus_requests (
    input  logic acc_i,
    input  logic rd_i,
    input  logic first_i,
    input  logic ack_slot_i,
    input  logic boundary_i,
    input  logic tx_full_i,
    input  logic rx_full_i,
    output logic hold_scl_o,
    output logic ack_sda_o
);

    // Acknowledge a matching address and every byte written to us.
    assign ack_sda_o  = ack_slot_i && acc_i && (first_i || !rd_i);

    // Hold the clock while the needed buffer is not ready.
    assign hold_scl_o = boundary_i && acc_i && (rd_i ? !tx_full_i : rx_full_i);

endmodule

// File: rtl/tws_slave_tracker.sv
// Top of the two-wire slave access tracker. Connects event detection,
// frame counting, access tracking and bus request forming. Assumes
// synchronized line inputs and synchronous active-low reset.
module tws_slave_tracker
    import tws_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              tx_full_i,
    input  logic              rx_full_i,
    output logic              acc_o,
    output logic              rd_o,
    output logic              gcall_o,
    output logic              acc_end_o,
    output logic              done_o,
    output logic              hold_scl_o,
    output logic              ack_sda_o
);

    localparam int BYTE_W = ADDR_W + 1;

    tws_evt_t          evt;
    logic [BYTE_W-1:0] byte_v;
    logic              byte_done, ack_rise, ack_end, ack_slot, first, boundary;

    tws_line_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    tws_frame_counter #(.BYTE_W(BYTE_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .sda_i       (sda_i),
        .byte_o      (byte_v),
        .byte_done_o (byte_done),
        .ack_rise_o  (ack_rise),
        .ack_end_o   (ack_end),
        .ack_slot_o  (ack_slot),
        .first_o     (first)
    );

    tws_access_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .sda_i       (sda_i),
        .own_addr_i  (own_addr_i),
        .byte_i      (byte_v),
        .byte_done_i (byte_done),
        .first_i     (first),
        .ack_rise_i  (ack_rise),
        .ack_end_i   (ack_end),
        .acc_o       (acc_o),
        .rd_o        (rd_o),
        .gcall_o     (gcall_o),
        .acc_end_o   (acc_end_o),
        .done_o      (done_o),
        .boundary_o  (boundary)
    );

    tws_bus_requests u_req (
        .acc_i      (acc_o),
        .rd_i       (rd_o),
        .first_i    (first),
        .ack_slot_i (ack_slot),
        .boundary_i (boundary),
        .tx_full_i  (tx_full_i),
        .rx_full_i  (rx_full_i),
        .hold_scl_o (hold_scl_o),
        .ack_sda_o  (ack_sda_o)
    );

endmodule

// File: rtl/tws_slave_tracker_chk.sv
// Property checker for the slave access tracker, attached by bind.
// Watches only the top-level ports.
module tws_slave_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic acc_o,
    input logic gcall_o,
    input logic acc_end_o,
    input logic done_o,
    input logic hold_scl_o,
    input logic ack_sda_o
);

    AST_END_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_end_o |-> (!acc_o && $past(acc_o)));  // R6

    AST_FALL_GIVES_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_o) |-> acc_end_o);  // R6

    AST_STOP_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> (done_o && !acc_o));  // R2

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> !done_o);  // R2

    AST_GCALL_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        gcall_o |-> acc_o);  // R7

    AST_HOLD_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_scl_o |-> acc_o);  // R10

    AST_ACK_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_sda_o) |-> !scl_i);  // R9

endmodule

bind tws_slave_tracker tws_slave_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .acc_o      (acc_o),
    .gcall_o    (gcall_o),
    .acc_end_o  (acc_end_o),
    .done_o     (done_o),
    .hold_scl_o (hold_scl_o),
    .ack_sda_o  (ack_sda_o)
);

// File: tb/tws_slave_tracker_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random bus transactions,
// checked against a bench-side model of the requirements.
module tws_slave_tracker_bench;

    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, txf = 1'b1, rxf = 1'b0;
    logic acc_o, rd_o, gcall_o, acc_end_o, done_o, hold_scl_o, ack_sda_o;

    int n_chk = 0, n_fail = 0, end_seen = 0;
    bit m_acc = 0, m_rd = 0, m_gc = 0, m_done = 1, m_busy = 0, m_rep = 0;
    int m_end = 0;
    bit prev_end = 0;

    always #2 clk = ~clk;

    tws_slave_tracker u_tws_slave_tracker (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .own_addr_i(OWN), .tx_full_i(txf), .rx_full_i(rxf),
        .acc_o(acc_o), .rd_o(rd_o), .gcall_o(gcall_o), .acc_end_o(acc_end_o),
        .done_o(done_o), .hold_scl_o(hold_scl_o), .ack_sda_o(ack_sda_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R6: count strobes and reject a strobe longer than one clock.
    always @(negedge clk) if (rst_n) begin
        if (acc_end_o) end_seen++;
        if (acc_end_o && prev_end) chk("R6 strobe width", 2, 1);
        prev_end = acc_end_o;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit hit(input logic [6:0] a, input logic rw);
        return (a == OWN) || (a == 7'h00 && rw == 1'b0);
    endfunction

    function automatic bit exp_hold(input bit t, input bit r);
        return m_acc && (m_rd ? !t : r);
    endfunction

    task automatic drop_access();
        if (m_acc) m_end++;
        m_acc = 0;
        m_gc  = 0;
    endtask

    task automatic send_bit(input logic b);
        sda = b; tick(3);
        scl = 1'b1; tick(3);
        scl = 1'b0; tick(3);
    endtask

    task automatic do_start();
        if (!scl) begin sda = 1'b1; tick(3); scl = 1'b1; tick(3); end
        sda = 1'b0; tick(3);
        m_done = 0; m_rep = m_busy; m_busy = 1;
        chk("R2 start clears done", done_o, 0);
        scl = 1'b0; tick(3);
    endtask

    task automatic do_stop();
        sda = 1'b0; tick(3);
        scl = 1'b1; tick(3);
        sda = 1'b1; tick(3);
        m_done = 1; m_busy = 0; m_rep = 0;
        drop_access();
        chk("R2 stop sets done", done_o, 1);
        chk("R4 stop clears access", acc_o, 0);
        chk("R6 end strobes", end_seen, m_end);
    endtask

    // Ninth clock: master drives v, buffers set to t/r, ack expected ea.
    task automatic ninth(input logic v, input bit ea, input bit t, input bit r,
                         input bit rd_data, input string tag);
        sda = v; txf = t; rxf = r; tick(3);
        chk({tag, " ack"}, ack_sda_o, ea);
        scl = 1'b1; tick(3);
        if (rd_data && m_acc && m_rd && v) drop_access();
        chk("R5 access after master ack", acc_o, m_acc);
        scl = 1'b0; tick(3);
        chk("R10 clock hold", hold_scl_o, exp_hold(t, r));
        txf = 1'b1; rxf = 1'b0; tick(1);
        chk("R10 hold released", hold_scl_o, 0);
    endtask

    task automatic do_addr(input logic [6:0] a, input logic rw, input bit t, input bit r);
        bit h;
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
        h = hit(a, rw);
        if (h) begin
            m_acc = 1; m_rd = rw; m_gc = (a == 7'h00 && rw == 1'b0);
        end else begin
            drop_access();
            if (m_rep) m_done = 1;
        end
        m_rep = 0;
        chk("R3 access flag", acc_o, m_acc);
        if (m_acc) chk("R3 direction", rd_o, m_rd);
        chk("R7 general call", gcall_o, m_gc);
        chk("R8 done after address", done_o, m_done);
        chk("R6 end strobes", end_seen, m_end);
        ninth(1'b1, h, t, r, 1'b0, "R9 address");
    endtask

    task automatic do_write(input logic [7:0] d, input bit t, input bit r);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        ninth(1'b1, m_acc && !m_rd, t, r, 1'b0, "R9 write data");
        chk("R4 access kept", acc_o, m_acc);
    endtask

    task automatic do_read(input logic [7:0] d, input bit nack, input bit t, input bit r);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        ninth(nack, 1'b0, t, r, 1'b1, "R9 read data");
        chk("R5 end strobes", end_seen, m_end);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned dummy;
        dummy = $urandom(32'd2024);
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset values
        chk("R1 acc", acc_o, 0);   chk("R1 rd", rd_o, 0);
        chk("R1 gcall", gcall_o, 0); chk("R1 end", acc_end_o, 0);
        chk("R1 done", done_o, 1); chk("R1 hold", hold_scl_o, 0);
        chk("R1 ack", ack_sda_o, 0);

        // Write access, two bytes, one with an unread receive buffer.
        do_start(); do_addr(OWN, 1'b0, 1, 0);
        do_write(8'hA5, 1, 1); do_write(8'h3C, 1, 0); do_stop();

        // Read access: ack, then empty transmit buffer, then NACK.
        do_start(); do_addr(OWN, 1'b1, 1, 0);
        do_read(8'h81, 1'b0, 0, 0); do_read(8'h7E, 1'b1, 1, 0);
        do_stop();

        // General call and the read-direction byte 0x01.
        do_start(); do_addr(7'h00, 1'b0, 1, 1); do_write(8'h06, 1, 0); do_stop();
        do_start(); do_addr(7'h00, 1'b1, 1, 0); do_stop();

        // Idle-bus mismatch keeps done low; repeated START mismatch sets it.
        do_start(); do_addr(7'h11, 1'b0, 1, 0);
        chk("R8 idle mismatch", done_o, 0);
        do_start(); do_addr(OWN, 1'b0, 1, 0);
        do_start(); do_addr(OWN, 1'b1, 1, 0);
        chk("R4 repeated start to own", end_seen, m_end);
        do_start(); do_addr(7'h22, 1'b0, 1, 0);
        chk("R8 repeated mismatch", done_o, 1);
        do_stop();

        // Seeded random transactions.
        for (int n = 0; n < 40; n++) begin
            logic [6:0] a;
            logic rw;
            int k, nb;
            do_start();
            k = $urandom % 4;
            rw = $urandom % 2;
            a = (k == 1) ? 7'h00 : (k == 2) ? 7'($urandom % 64 + 1) : OWN;
            if (a == OWN && k == 2) a = 7'h01;
            if (k == 1) rw = 1'b0;
            do_addr(a, rw, 1'($urandom), 1'($urandom));
            nb = $urandom % 3 + 1;
            for (int b = 0; b < nb; b++) begin
                if (m_acc && m_rd)
                    do_read(8'($urandom), (b == nb - 1) && ($urandom % 2 == 1),
                            1'($urandom), 1'($urandom));
                else
                    do_write(8'($urandom), 1'($urandom), 1'($urandom));
            end
            if ($urandom % 3 != 0) do_stop();
        end
        do_stop();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule